// File: doc/BRIEF.md
# Battery-Backed SRAM Chip-Enable Guard

This block sits in the chip-enable path between a host and one asynchronous static RAM that falls back to battery power when the main supply fails. Digital flags from external comparators feed it. They report whether the supply is above the operating level and whether it is above the switchover level. Two further flags report whether each of two batteries has dropped below its warning level, and a last flag says which battery currently holds the higher voltage. The block forwards the host chip-enable to the memory only while the supply is valid. When the supply drops it forces the memory into write protection. After the supply returns it keeps that protection for a fixed recovery time, counted in clock cycles.

At each power restoration the block samples both battery-low flags once and keeps the result. If both batteries were low, it signals this by refusing the second memory access after the restore. The host writes a location, then reads it back, and finds the data unchanged. A warning output reflects the same latched condition. Whenever the supply is below the switchover level the block also drives the backup-source select. It picks the battery that is higher, or the one that still reports good.

All comparator flags pass through two-flop synchronizers. Host chip-enable and write-enable are synchronous to the block clock. Reset leaves the block in the protected state.

Top module: `nvg_ce_guard`

## Requirements
- R1: Within 3 clock cycles of `sup_ok_raw` going low, `mem_ce_n` is 1. It stays 1, whatever `host_ce_n` does, until the supply has been restored and the recovery period has elapsed.
- R2: After `sup_ok_raw` returns high, `mem_ce_n` stays 1 for at least `REC_CYC` cycles, even if the host asserts chip-enable during that time.
- R3: `use_backup` is 1 while `sup_sw_raw` is low and 0 while it is high, following each change within 4 cycles.
- R4: At each restoration both battery-low flags are sampled once. `bat_warn` is 1 exactly when both were low at that sample, and it holds that value until the next restoration.
- R5: When both batteries were latched low, the first access after the restore passes normally. The second access (counted on falling edges of `host_ce_n` outside protection) is held at `mem_ce_n` = 1 for its whole duration. The third and later accesses pass normally.
- R6: `bat_sel_b` (1 selects battery B) follows this rule. If exactly one battery is low, the other is selected. Otherwise battery B is selected when `bat_a_hi_raw` is 0, and battery A when it is 1.
- R7: An access that passes is never cut short. While the supply stays valid, `mem_ce_n` stays 0 until `host_ce_n` returns high. If `host_ce_n` is already low when protection ends, that access is not forwarded; only a fresh falling edge starts one.
- R8: The access count is cleared at every restoration, so after a new restore with both batteries low, the first access passes again.
- R9: After reset, `mem_ce_n` is 1, `use_backup` is 1 and `bat_warn` is 0.
- R10: A restoration at which the batteries test good clears `bat_warn` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| host_ce_n | input | 1 | Host chip-enable, active low |
| host_we_n | input | 1 | Host write-enable, active low (observed only by the checker) |
| sup_ok_raw | input | 1 | Supply above operating level (asynchronous) |
| sup_sw_raw | input | 1 | Supply above switchover level (asynchronous) |
| bat_a_low_raw | input | 1 | Battery A below warning level (asynchronous) |
| bat_b_low_raw | input | 1 | Battery B below warning level (asynchronous) |
| bat_a_hi_raw | input | 1 | Battery A voltage above battery B (asynchronous) |
| mem_ce_n | output | 1 | Gated chip-enable to the SRAM, active low, registered |
| use_backup | output | 1 | 1 connects the battery source to the SRAM |
| bat_sel_b | output | 1 | Backup battery select: 1 = B, 0 = A |
| bat_warn | output | 1 | Both batteries were low at the last restoration |

## Verification
The interesting collision is a supply failure landing in the middle of a forwarded access. The no-cut rule wants `mem_ce_n` held low, while the fail protection wants it forced high. The bench holds an access open, drops `sup_ok_raw` and expects `mem_ce_n` high within the R1 bound. This confirms that the fail path outranks the no-cut rule. A second overlap has the recovery period ending while the host already holds chip-enable low. The bench keeps `host_ce_n` low across the end of recovery and judges that the memory stays deselected until a fresh falling edge.

// File: rtl/nvg_pkg.sv
package nvg_pkg;
  typedef enum logic [1:0] {
    PW_DOWN  = 2'd0,
    PW_RECOV = 2'd1,
    PW_RUN   = 2'd2
  } pw_state_t;

  localparam int FLAG_N   = 5;
  localparam int F_OK     = 0;
  localparam int F_SW     = 1;
  localparam int F_ALOW   = 2;
  localparam int F_BLOW   = 3;
  localparam int F_AHI    = 4;
  localparam int ACC_W    = 2;
  localparam int ACC_SAT  = 2;
endpackage

// File: rtl/nvg_sync.sv
module nvg_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d_async[i];
        s2 <= s1;
      end
    end
    assign q_sync[i] = s2;
  end
endmodule

// File: rtl/nvg_power.sv
module nvg_power
  import nvg_pkg::*;
#(
  parameter int REC_CYC = 12_500_000
) (
  input  logic clk,
  input  logic rst,
  input  logic ok_s,
  output logic run,
  output logic restore
);
  localparam int CW = $clog2(REC_CYC + 1);

  pw_state_t      state;
  logic [CW-1:0]  rcnt;

  assign restore = (state == PW_DOWN) && ok_s;
  assign run     = (state == PW_RUN) && ok_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= PW_DOWN;
      rcnt  <= '0;
    end else if (!ok_s) begin
      state <= PW_DOWN;
      rcnt  <= '0;
    end else begin
      case (state)
        PW_DOWN: begin
          state <= PW_RECOV;
          rcnt  <= '0;
        end
        PW_RECOV: begin
          if (rcnt == CW'(REC_CYC - 1)) state <= PW_RUN;
          else rcnt <= rcnt + 1'b1;
        end
        default: state <= PW_RUN;
      endcase
    end
  end
endmodule

// File: rtl/nvg_battery.sv
module nvg_battery (
  input  logic clk,
  input  logic rst,
  input  logic restore,
  input  logic sw_s,
  input  logic a_low_s,
  input  logic b_low_s,
  input  logic a_hi_s,
  output logic both_low,
  output logic use_backup,
  output logic sel_b
);
  logic pick_b;

  always_comb begin
    if (a_low_s && !b_low_s)      pick_b = 1'b1;
    else if (b_low_s && !a_low_s) pick_b = 1'b0;
    else                          pick_b = !a_hi_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      both_low   <= 1'b0;
      use_backup <= 1'b1;
      sel_b      <= 1'b0;
    end else begin
      if (restore) both_low <= a_low_s && b_low_s;
      use_backup <= !sw_s;
      sel_b      <= pick_b;
    end
  end
endmodule

// File: rtl/nvg_gate.sv
module nvg_gate
  import nvg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restore,
  input  logic both_low,
  input  logic host_ce_n,
  output logic mem_ce_n
);
  logic             prev_ce_n;
  logic             armed;
  logic             block_hold;
  logic [ACC_W-1:0] acc_cnt;
  logic             fall, second, block_now;

  assign fall      = prev_ce_n && !host_ce_n;
  assign second    = both_low && (acc_cnt == ACC_W'(1));
  assign block_now = fall ? second : block_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_ce_n  <= 1'b1;
      armed      <= 1'b0;
      block_hold <= 1'b0;
      acc_cnt    <= '0;
      mem_ce_n   <= 1'b1;
    end else begin
      prev_ce_n  <= host_ce_n;
      armed      <= run && (armed || host_ce_n);
      block_hold <= host_ce_n ? 1'b0 : block_now;
      if (restore)
        acc_cnt <= '0;
      else if (run && armed && fall && acc_cnt != ACC_W'(ACC_SAT))
        acc_cnt <= acc_cnt + 1'b1;
      mem_ce_n <= !(run && armed && !host_ce_n && !block_now);
    end
  end
endmodule

// File: rtl/nvg_ce_guard.sv
module nvg_ce_guard
  import nvg_pkg::*;
#(
  parameter int REC_CYC = 12_500_000
) (
  input  logic clk,
  input  logic rst,
  input  logic host_ce_n,
  input  logic host_we_n,
  input  logic sup_ok_raw,
  input  logic sup_sw_raw,
  input  logic bat_a_low_raw,
  input  logic bat_b_low_raw,
  input  logic bat_a_hi_raw,
  output logic mem_ce_n,
  output logic use_backup,
  output logic bat_sel_b,
  output logic bat_warn
);
  logic [FLAG_N-1:0] flags_raw, flags_s;
  logic ok_s, sw_s, a_low_s, b_low_s, a_hi_s;
  logic run, restore, both_low;

  assign flags_raw = {bat_a_hi_raw, bat_b_low_raw, bat_a_low_raw, sup_sw_raw, sup_ok_raw};

  nvg_sync #(.W(FLAG_N)) u_sync (
    .clk(clk), .rst(rst), .d_async(flags_raw), .q_sync(flags_s)
  );

  assign ok_s    = flags_s[F_OK];
  assign sw_s    = flags_s[F_SW];
  assign a_low_s = flags_s[F_ALOW];
  assign b_low_s = flags_s[F_BLOW];
  assign a_hi_s  = flags_s[F_AHI];

  nvg_power #(.REC_CYC(REC_CYC)) u_power (
    .clk(clk), .rst(rst), .ok_s(ok_s), .run(run), .restore(restore)
  );

  nvg_battery u_bat (
    .clk(clk), .rst(rst), .restore(restore), .sw_s(sw_s),
    .a_low_s(a_low_s), .b_low_s(b_low_s), .a_hi_s(a_hi_s),
    .both_low(both_low), .use_backup(use_backup), .sel_b(bat_sel_b)
  );

  nvg_gate u_gate (
    .clk(clk), .rst(rst), .run(run), .restore(restore),
    .both_low(both_low), .host_ce_n(host_ce_n), .mem_ce_n(mem_ce_n)
  );

  assign bat_warn = both_low;
endmodule

// File: rtl/nvg_ce_guard_chk.sv
module nvg_ce_guard_chk #(
  parameter int REC_CYC = 12_500_000
) (
  input logic clk,
  input logic rst,
  input logic host_ce_n,
  input logic host_we_n,
  input logic mem_ce_n,
  input logic ok_s,
  input logic sw_s,
  input logic a_low_s,
  input logic b_low_s,
  input logic restore,
  input logic use_backup,
  input logic bat_sel_b,
  input logic bat_warn
);
  logic        rec_on;
  logic [31:0] rec_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_on  <= 1'b0;
      rec_cnt <= '0;
    end else if (restore) begin
      rec_on  <= 1'b1;
      rec_cnt <= '0;
    end else if (rec_on) begin
      if (rec_cnt >= 32'(REC_CYC)) rec_on <= 1'b0;
      else rec_cnt <= rec_cnt + 1'b1;
    end
  end

  // R1
  a_r1_fail_deselect: assert property (@(posedge clk) disable iff (rst)
    !ok_s |=> mem_ce_n);
  // R2
  a_r2_recovery_hold: assert property (@(posedge clk) disable iff (rst)
    (rec_on && rec_cnt < 32'(REC_CYC)) |-> mem_ce_n);
  // R3
  a_r3_backup_on: assert property (@(posedge clk) disable iff (rst)
    $fell(sw_s) |=> use_backup);
  // R4
  a_r4_warn_latch: assert property (@(posedge clk) disable iff (rst)
    restore |=> (bat_warn == $past(a_low_s && b_low_s)));
  // R6
  a_r6_sel_b_when_a_low: assert property (@(posedge clk) disable iff (rst)
    (a_low_s && !b_low_s) |=> bat_sel_b);
  a_r6_sel_a_when_b_low: assert property (@(posedge clk) disable iff (rst)
    (!a_low_s && b_low_s) |=> !bat_sel_b);
  // R7
  a_r7_no_cut: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && !host_ce_n && ok_s) |=> !mem_ce_n);
  // R4 stability between restorations
  a_r4_warn_stable: assert property (@(posedge clk) disable iff (rst)
    !restore |=> $stable(bat_warn));
endmodule

bind nvg_ce_guard nvg_ce_guard_chk #(.REC_CYC(REC_CYC)) u_chk (
  .clk(clk), .rst(rst), .host_ce_n(host_ce_n), .host_we_n(host_we_n),
  .mem_ce_n(mem_ce_n), .ok_s(ok_s), .sw_s(sw_s), .a_low_s(a_low_s),
  .b_low_s(b_low_s), .restore(restore), .use_backup(use_backup),
  .bat_sel_b(bat_sel_b), .bat_warn(bat_warn)
);

// File: tb/nvg_ce_guard_test.sv
module nvg_ce_guard_test;
  localparam int REC = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_ce_n = 1'b1, host_we_n = 1'b1;
  logic sup_ok_raw = 1'b0, sup_sw_raw = 1'b0;
  logic bat_a_low_raw = 1'b0, bat_b_low_raw = 1'b0, bat_a_hi_raw = 1'b0;
  logic mem_ce_n, use_backup, bat_sel_b, bat_warn;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nvg_ce_guard #(.REC_CYC(REC)) uut (
    .clk(clk), .rst(rst), .host_ce_n(host_ce_n), .host_we_n(host_we_n),
    .sup_ok_raw(sup_ok_raw), .sup_sw_raw(sup_sw_raw),
    .bat_a_low_raw(bat_a_low_raw), .bat_b_low_raw(bat_b_low_raw),
    .bat_a_hi_raw(bat_a_hi_raw), .mem_ce_n(mem_ce_n),
    .use_backup(use_backup), .bat_sel_b(bat_sel_b), .bat_warn(bat_warn)
  );

  // {a_low, b_low, a_hi, expected sel_b}
  localparam logic [3:0] SEL_TAB [8] = '{
    4'b0000 | 4'b0001, 4'b0010, 4'b0100, 4'b0110,
    4'b1001, 4'b1011, 4'b1101, 4'b1110
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic access(input string req, input logic exp_ce);
    host_ce_n = 1'b0; host_we_n = 1'b0;
    cyc(2);
    chk(req, mem_ce_n, exp_ce);
    cyc(3);
    chk(req, mem_ce_n, exp_ce);
    host_ce_n = 1'b1; host_we_n = 1'b1;
    cyc(3);
    chk(req, mem_ce_n, 1'b1);
  endtask

  task automatic power_cycle(input logic alow, input logic blow);
    sup_ok_raw = 1'b0; sup_sw_raw = 1'b0;
    cyc(6);
    bat_a_low_raw = alow; bat_b_low_raw = blow;
    cyc(4);
    sup_sw_raw = 1'b1; sup_ok_raw = 1'b1;
    cyc(REC + 8);
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R9 reset state
    chk("R9 mem_ce_n", mem_ce_n, 1'b1);
    chk("R9 use_backup", use_backup, 1'b1);
    chk("R9 bat_warn", bat_warn, 1'b0);

    // R6 selection table
    for (int i = 0; i < 8; i++) begin
      {bat_a_low_raw, bat_b_low_raw, bat_a_hi_raw} = SEL_TAB[i][3:1];
      cyc(5);
      chk("R6 bat_sel_b", bat_sel_b, SEL_TAB[i][0]);
    end
    bat_a_low_raw = 1'b0; bat_b_low_raw = 1'b0; bat_a_hi_raw = 1'b0;
    cyc(5);

    // power up with good batteries
    sup_sw_raw = 1'b1; sup_ok_raw = 1'b1;
    cyc(5);
    chk("R3 use_backup off", use_backup, 1'b0);
    host_ce_n = 1'b0;
    cyc(3);
    chk("R2 held during recovery", mem_ce_n, 1'b1);
    cyc(REC + 6);
    chk("R7 ce low across recovery end", mem_ce_n, 1'b1);
    host_ce_n = 1'b1;
    cyc(3);
    chk("R4 warn good", bat_warn, 1'b0);
    access("R2 pass after recovery", 1'b0);

    // R1 supply fail mid-access
    host_ce_n = 1'b0;
    cyc(3);
    chk("R7 access open", mem_ce_n, 1'b0);
    sup_ok_raw = 1'b0;
    cyc(3);
    chk("R1 deselect on fail", mem_ce_n, 1'b1);
    host_ce_n = 1'b1; cyc(2); host_ce_n = 1'b0; cyc(3);
    chk("R1 host ignored", mem_ce_n, 1'b1);
    host_ce_n = 1'b1;
    sup_sw_raw = 1'b0;
    cyc(5);
    chk("R3 use_backup on", use_backup, 1'b1);

    // both batteries low at restore
    power_cycle(1'b1, 1'b1);
    chk("R4 warn set", bat_warn, 1'b1);
    access("R5 first access", 1'b0);
    access("R5 second blocked", 1'b1);
    access("R5 third access", 1'b0);
    bat_a_low_raw = 1'b0;
    cyc(5);
    chk("R4 warn holds", bat_warn, 1'b1);

    // R8 count cleared at each restore
    power_cycle(1'b1, 1'b1);
    access("R8 first after new restore", 1'b0);
    access("R8 second blocked again", 1'b1);

    // R10 good restore clears warning
    power_cycle(1'b0, 1'b0);
    chk("R10 warn cleared", bat_warn, 1'b0);
    access("R10 first", 1'b0);
    access("R10 second passes", 1'b0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule